// File: doc/BRIEF.md
# Dual converter synchronous sequencer

This block sits between two conversion cores and the system. One core is the master and the other is the slave. Each core is driven through a simple start, done and data handshake. The block walks each core through a programmed list of input channels, slot by slot. A sequence runs from 1 to 16 conversions, and each result is 12 bits wide.

The block has two modes. In independent mode the two cores are not coupled. The master sequence is launched by an edge on one of eight selectable trigger sources, and the slave sequence is launched by an edge on its own trigger input. In synchronous mode a single edge on the selected source starts both cores in the same cycle. A slot then advances only once both cores have reported done. Each pair of results is packed into one 32-bit word: the slave result sits in the upper half and the master result in the lower half. A one-cycle DMA request is raised for each packed word.

The block also raises an end-of-sequence interrupt for each core. It refuses to start a synchronous run when both cores would sample the same channel in the same slot. It keeps a sticky overrun flag for packed words that are overwritten before they are acknowledged.

Top module: `dual_conv_seq`

## Requirements
- R1: With `cfg_sync_mode`=0, an edge on the selected source runs only the master sequence and an edge on `slv_trig` runs only the slave sequence. Each result appears on `m_res`/`s_res` (12 bits right-aligned, upper 4 bits zero) with a one-cycle `m_res_vld`/`s_res_vld`, and each core steps on its own done.
- R2: With `cfg_sync_mode`=1, the master source is `trig_src[cfg_trig_sel]`, and edges on the other sources start nothing. `m_start` and `s_start` are asserted in the same cycles. A slot advances only after both `m_done` and `s_done` have been seen.
- R3: With `cfg_sync_mode`=1, edges on `slv_trig` start no conversion.
- R4: A packed word holds the slave result in bits 31:16 and the master result in bits 15:0. Each half is 12 bits right-aligned with bits 15:12 zero.
- R5: When a core's sequence completes, its `eoc_irq_m`/`eoc_irq_s` pulses for one cycle if `cfg_ie_m`/`cfg_ie_s` is 1. The pulse stays low if the enable is 0.
- R6: With `cfg_sync_mode`=1 and `cfg_dma_en`=0, triggers start nothing.
- R7: At an accepted synchronous trigger edge, if any slot i with i <= `cfg_len_m` has the same channel in both lists, `cfg_err` goes to 1 and nothing starts. The next trigger edge without a clash clears `cfg_err` and starts the run. Clashes at slots beyond the length are ignored.
- R8: Triggers pass through a two-flop synchronizer and act on their rising edge. One edge starts exactly one sequence, and edges that arrive while the sequence is busy are ignored.
- R9: Each packed word is accompanied by exactly one `dma_req` pulse, one cycle long.
- R10: A sequence has length field + 1 conversions (1 to 16). Slot i uses channel bits [5i+4:5i] of the list, in order, starting at slot 0. In synchronous mode both cores use `cfg_len_m`.
- R11: If a packed word is written while the previous word is still unacknowledged by `dma_ack`, `overrun` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync_mode | input | 1 | 1 = synchronous, 0 = independent |
| cfg_trig_sel | input | 3 | Index of master trigger source |
| cfg_dma_en | input | 1 | DMA path enable, required in synchronous mode |
| cfg_ie_m | input | 1 | Master end-of-sequence interrupt enable |
| cfg_ie_s | input | 1 | Slave end-of-sequence interrupt enable |
| cfg_len_m | input | 4 | Master sequence length minus one |
| cfg_len_s | input | 4 | Slave sequence length minus one (independent mode) |
| cfg_chans_m | input | 80 | Master channel list, 5 bits per slot |
| cfg_chans_s | input | 80 | Slave channel list, 5 bits per slot |
| trig_src | input | 8 | External trigger sources for the master |
| slv_trig | input | 1 | Slave's own trigger |
| m_start | output | 1 | Master conversion start pulse |
| m_chan | output | 5 | Master channel for current slot |
| m_done | input | 1 | Master conversion done |
| m_data | input | 12 | Master conversion result |
| s_start | output | 1 | Slave conversion start pulse |
| s_chan | output | 5 | Slave channel for current slot |
| s_done | input | 1 | Slave conversion done |
| s_data | input | 12 | Slave conversion result |
| m_res | output | 16 | Last master result |
| m_res_vld | output | 1 | Master result strobe |
| s_res | output | 16 | Last slave result |
| s_res_vld | output | 1 | Slave result strobe |
| pack_dat | output | 32 | Packed result pair |
| dma_req | output | 1 | DMA request pulse per packed word |
| dma_ack | input | 1 | DMA acknowledge of the pending word |
| eoc_irq_m | output | 1 | Master end-of-sequence interrupt pulse |
| eoc_irq_s | output | 1 | Slave end-of-sequence interrupt pulse |
| cfg_err | output | 1 | Channel clash on last synchronous trigger |
| overrun | output | 1 | Sticky packed-word overrun |

## Verification
A slot counter that drifts shows up at once on `m_chan`/`s_chan`. The wrong result value then reaches the next packed word a few cycles after the core answers. Lost lockstep between the two engines is visible in the very cycle the start strobes differ. A pending-word flag in the wrong state shows as an overrun, or a missing one, at the next `dma_req`. Start counts and interrupt counts taken after each run expose extra or missing sequence launches, including triggers that should have been dropped.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int DCS_N_SRC  = 8;
  localparam int DCS_LEN_W  = 4;
  localparam int DCS_CH_W   = 5;
  localparam int DCS_RES_W  = 12;
  localparam int DCS_HALF_W = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/dcs_trig_sync.sv
`timescale 1ns/1ps
module dcs_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/dcs_chan_guard.sv
`timescale 1ns/1ps
module dcs_chan_guard #(
  parameter int LEN_W = 4,
  parameter int CH_W  = 5
) (
  input  logic [LEN_W-1:0]              len_i,
  input  logic [(1<<LEN_W)*CH_W-1:0]    chans_a_i,
  input  logic [(1<<LEN_W)*CH_W-1:0]    chans_b_i,
  output logic                          clash_o
);
  localparam int SLOTS = 1 << LEN_W;

  logic [SLOTS-1:0] hit;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign hit[i] = (LEN_W'(i) <= len_i) &&
                    (chans_a_i[i*CH_W +: CH_W] == chans_b_i[i*CH_W +: CH_W]);
  end

  assign clash_o = |hit;
endmodule

// File: rtl/dcs_seq_core.sv
`timescale 1ns/1ps
module dcs_seq_core
  import dcs_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [(1<<LEN_W)*CH_W-1:0]    chans_i,
  input  logic                          adv_i,
  input  logic                          conv_done_i,
  input  logic [RES_W-1:0]              conv_data_i,
  output logic                          conv_start_o,
  output logic [CH_W-1:0]               conv_chan_o,
  output logic                          idle_o,
  output logic                          have_o,
  output logic [RES_W-1:0]              data_o,
  output logic [RES_W-1:0]              res_o,
  output logic                          res_vld_o,
  output logic                          eos_o
);
  localparam int SLOTS = 1 << LEN_W;

  seq_st_e          st_q, st_n;
  logic [LEN_W-1:0] slot_q, slot_n;
  logic [RES_W-1:0] data_q, res_q;
  logic             data_en, res_en, eos_n;
  logic             res_vld_q, eos_q;
  logic [CH_W-1:0]  ch_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_unpack
    assign ch_arr[i] = chans_i[i*CH_W +: CH_W];
  end

  always_comb begin
    st_n    = st_q;
    slot_n  = slot_q;
    data_en = 1'b0;
    res_en  = 1'b0;
    eos_n   = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (go_i) begin
          st_n   = SEQ_START;
          slot_n = '0;
        end
      end
      SEQ_START: st_n = SEQ_WAIT;
      SEQ_WAIT: begin
        if (conv_done_i) begin
          st_n    = SEQ_HOLD;
          data_en = 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (adv_i) begin
          res_en = 1'b1;
          if (slot_q == len_i) begin
            st_n  = SEQ_IDLE;
            eos_n = 1'b1;
          end else begin
            slot_n = slot_q + 1'b1;
            st_n   = SEQ_START;
          end
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      slot_q    <= '0;
      res_vld_q <= 1'b0;
      eos_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      slot_q    <= slot_n;
      res_vld_q <= res_en;
      eos_q     <= eos_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= conv_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= data_q;
    end
  end

  assign conv_start_o = (st_q == SEQ_START);
  assign conv_chan_o  = ch_arr[slot_q];
  assign idle_o       = (st_q == SEQ_IDLE);
  assign have_o       = (st_q == SEQ_HOLD);
  assign data_o       = data_q;
  assign res_o        = res_q;
  assign res_vld_o    = res_vld_q;
  assign eos_o        = eos_q;
endmodule

// File: rtl/dcs_pack.sv
`timescale 1ns/1ps
module dcs_pack #(
  parameter int HALF_W = 16,
  parameter int RES_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [RES_W-1:0]      m_data_i,
  input  logic [RES_W-1:0]      s_data_i,
  input  logic                  ack_i,
  output logic [2*HALF_W-1:0]   word_o,
  output logic                  req_o,
  output logic                  ovr_o
);
  localparam int PAD_W = HALF_W - RES_W;

  logic [2*HALF_W-1:0] word_q, word_d;
  logic                req_q, pend_q, pend_n, ovr_q, ovr_set;

  always_comb begin
    word_d  = {{PAD_W{1'b0}}, s_data_i, {PAD_W{1'b0}}, m_data_i};
    ovr_set = wr_i & pend_q & ~ack_i;
    if (wr_i)       pend_n = 1'b1;
    else if (ack_i) pend_n = 1'b0;
    else            pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= wr_i;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_i) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (ovr_set) begin
      ovr_q <= 1'b1;
    end
  end

  assign word_o = word_q;
  assign req_o  = req_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/dual_conv_seq.sv
`timescale 1ns/1ps
module dual_conv_seq
  import dcs_pkg::*;
#(
  parameter int N_SRC  = DCS_N_SRC,
  parameter int SEL_W  = $clog2(DCS_N_SRC),
  parameter int LEN_W  = DCS_LEN_W,
  parameter int CH_W   = DCS_CH_W,
  parameter int RES_W  = DCS_RES_W,
  parameter int HALF_W = DCS_HALF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_sync_mode,
  input  logic [SEL_W-1:0]            cfg_trig_sel,
  input  logic                        cfg_dma_en,
  input  logic                        cfg_ie_m,
  input  logic                        cfg_ie_s,
  input  logic [LEN_W-1:0]            cfg_len_m,
  input  logic [LEN_W-1:0]            cfg_len_s,
  input  logic [(1<<LEN_W)*CH_W-1:0]  cfg_chans_m,
  input  logic [(1<<LEN_W)*CH_W-1:0]  cfg_chans_s,
  input  logic [N_SRC-1:0]            trig_src,
  input  logic                        slv_trig,
  output logic                        m_start,
  output logic [CH_W-1:0]             m_chan,
  input  logic                        m_done,
  input  logic [RES_W-1:0]            m_data,
  output logic                        s_start,
  output logic [CH_W-1:0]             s_chan,
  input  logic                        s_done,
  input  logic [RES_W-1:0]            s_data,
  output logic [HALF_W-1:0]           m_res,
  output logic                        m_res_vld,
  output logic [HALF_W-1:0]           s_res,
  output logic                        s_res_vld,
  output logic [2*HALF_W-1:0]         pack_dat,
  output logic                        dma_req,
  input  logic                        dma_ack,
  output logic                        eoc_irq_m,
  output logic                        eoc_irq_s,
  output logic                        cfg_err,
  output logic                        overrun
);
  localparam int PAD_W = HALF_W - RES_W;

  logic             trig_m_raw, rise_m, rise_s;
  logic             idle_m, idle_s, have_m, have_s;
  logic             go_m, go_s, adv_m, adv_s;
  logic             sync_try, sync_go, clash, pair_wr;
  logic [LEN_W-1:0] len_s_eff;
  logic [RES_W-1:0] data_m, data_s, res_m, res_s;
  logic             eos_m, eos_s;
  logic             err_q;

  assign trig_m_raw = trig_src[cfg_trig_sel];

  dcs_trig_sync u_sync_m (.clk(clk), .rst_n(rst_n), .raw_i(trig_m_raw), .rise_o(rise_m));
  dcs_trig_sync u_sync_s (.clk(clk), .rst_n(rst_n), .raw_i(slv_trig),   .rise_o(rise_s));

  dcs_chan_guard #(.LEN_W(LEN_W), .CH_W(CH_W)) u_guard (
    .len_i     (cfg_len_m),
    .chans_a_i (cfg_chans_m),
    .chans_b_i (cfg_chans_s),
    .clash_o   (clash)
  );

  always_comb begin
    sync_try  = cfg_sync_mode & cfg_dma_en & rise_m & idle_m & idle_s;
    sync_go   = sync_try & ~clash;
    pair_wr   = cfg_sync_mode & have_m & have_s;
    len_s_eff = cfg_sync_mode ? cfg_len_m : cfg_len_s;
    if (cfg_sync_mode) begin
      go_m  = sync_go;
      go_s  = sync_go;
      adv_m = pair_wr;
      adv_s = pair_wr;
    end else begin
      go_m  = rise_m & idle_m;
      go_s  = rise_s & idle_s;
      adv_m = have_m;
      adv_s = have_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (sync_try) begin
      err_q <= clash;
    end
  end

  dcs_seq_core #(.LEN_W(LEN_W), .CH_W(CH_W), .RES_W(RES_W)) u_eng_m (
    .clk(clk), .rst_n(rst_n), .go_i(go_m), .len_i(cfg_len_m), .chans_i(cfg_chans_m),
    .adv_i(adv_m), .conv_done_i(m_done), .conv_data_i(m_data),
    .conv_start_o(m_start), .conv_chan_o(m_chan), .idle_o(idle_m), .have_o(have_m),
    .data_o(data_m), .res_o(res_m), .res_vld_o(m_res_vld), .eos_o(eos_m)
  );

  dcs_seq_core #(.LEN_W(LEN_W), .CH_W(CH_W), .RES_W(RES_W)) u_eng_s (
    .clk(clk), .rst_n(rst_n), .go_i(go_s), .len_i(len_s_eff), .chans_i(cfg_chans_s),
    .adv_i(adv_s), .conv_done_i(s_done), .conv_data_i(s_data),
    .conv_start_o(s_start), .conv_chan_o(s_chan), .idle_o(idle_s), .have_o(have_s),
    .data_o(data_s), .res_o(res_s), .res_vld_o(s_res_vld), .eos_o(eos_s)
  );

  dcs_pack #(.HALF_W(HALF_W), .RES_W(RES_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .wr_i(pair_wr), .m_data_i(data_m), .s_data_i(data_s),
    .ack_i(dma_ack), .word_o(pack_dat), .req_o(dma_req), .ovr_o(overrun)
  );

  assign m_res     = {{PAD_W{1'b0}}, res_m};
  assign s_res     = {{PAD_W{1'b0}}, res_s};
  assign eoc_irq_m = eos_m & cfg_ie_m;
  assign eoc_irq_s = eos_s & cfg_ie_s;
  assign cfg_err   = err_q;
endmodule

// File: rtl/dcs_chk.sv
`timescale 1ns/1ps
module dcs_chk #(
  parameter int HALF_W = 16,
  parameter int RES_W  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_mode,
  input logic                m_start,
  input logic                s_start,
  input logic                dma_req,
  input logic [2*HALF_W-1:0] pack_dat,
  input logic                overrun
);
  p_lockstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && m_start) |-> s_start);

  p_slave_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && s_start) |-> m_start);

  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (pack_dat[2*HALF_W-1:HALF_W+RES_W] == '0 && pack_dat[HALF_W-1:RES_W] == '0));

  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_start |=> !m_start);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  p_ovr_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> dma_req);
endmodule

bind dual_conv_seq dcs_chk #(.HALF_W(HALF_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(cfg_sync_mode), .m_start(m_start),
  .s_start(s_start), .dma_req(dma_req), .pack_dat(pack_dat), .overrun(overrun)
);

// File: tb/dual_conv_seq_tb.sv
`timescale 1ns/1ps
module dual_conv_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sync_mode, cfg_dma_en, cfg_ie_m, cfg_ie_s;
  logic [2:0]  cfg_trig_sel;
  logic [3:0]  cfg_len_m, cfg_len_s;
  logic [79:0] cfg_chans_m, cfg_chans_s;
  logic [7:0]  trig_src;
  logic        slv_trig;
  logic        m_start, s_start, m_done, s_done;
  logic [4:0]  m_chan, s_chan;
  logic [11:0] m_data, s_data;
  logic [15:0] m_res, s_res;
  logic        m_res_vld, s_res_vld;
  logic [31:0] pack_dat;
  logic        dma_req, dma_ack;
  logic        eoc_irq_m, eoc_irq_s, cfg_err, overrun;

  int nchecks = 0, nerrors = 0;
  int dly_m = 3, dly_s = 5;
  int cnt_m = 0, cnt_s = 0;
  logic [4:0] chm_l = '0, chs_l = '0;
  bit auto_ack = 1'b1;
  int n_mstart = 0, n_sstart = 0, n_irq_m = 0, n_irq_s = 0, n_req = 0;
  logic [15:0] q_m[$];
  logic [15:0] q_s[$];
  logic [31:0] q_p[$];

  always #2.5 clk = ~clk;

  dual_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sync_mode(cfg_sync_mode), .cfg_trig_sel(cfg_trig_sel),
    .cfg_dma_en(cfg_dma_en), .cfg_ie_m(cfg_ie_m), .cfg_ie_s(cfg_ie_s),
    .cfg_len_m(cfg_len_m), .cfg_len_s(cfg_len_s), .cfg_chans_m(cfg_chans_m),
    .cfg_chans_s(cfg_chans_s), .trig_src(trig_src), .slv_trig(slv_trig),
    .m_start(m_start), .m_chan(m_chan), .m_done(m_done), .m_data(m_data),
    .s_start(s_start), .s_chan(s_chan), .s_done(s_done), .s_data(s_data),
    .m_res(m_res), .m_res_vld(m_res_vld), .s_res(s_res), .s_res_vld(s_res_vld),
    .pack_dat(pack_dat), .dma_req(dma_req), .dma_ack(dma_ack),
    .eoc_irq_m(eoc_irq_m), .eoc_irq_s(eoc_irq_s), .cfg_err(cfg_err), .overrun(overrun)
  );

  function automatic logic [11:0] mval(logic [4:0] c);
    return 12'(int'(c) * 37 + 5);
  endfunction

  function automatic logic [11:0] sval(logic [4:0] c);
    return 12'(int'(c) * 53 + 900);
  endfunction

  function automatic logic [79:0] mk_chans(int base);
    logic [79:0] v;
    for (int i = 0; i < 16; i++) v[i*5 +: 5] = 5'((i*3 + base) % 32);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter core models
  always @(posedge clk) begin
    if (m_start) begin cnt_m <= dly_m; chm_l <= m_chan; end
    else if (cnt_m != 0) cnt_m <= cnt_m - 1;
    m_done <= (!m_start && cnt_m == 1);
    m_data <= mval(chm_l);
    if (s_start) begin cnt_s <= dly_s; chs_l <= s_chan; end
    else if (cnt_s != 0) cnt_s <= cnt_s - 1;
    s_done <= (!s_start && cnt_s == 1);
    s_data <= sval(chs_l);
    dma_ack <= auto_ack && dma_req;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_start) n_mstart++;
      if (s_start) n_sstart++;
      if (eoc_irq_m) n_irq_m++;
      if (eoc_irq_s) n_irq_s++;
      if (cfg_sync_mode && (m_start || s_start))
        chk(m_start == s_start, "R2/R3 lockstep start", {31'b0, s_start}, {31'b0, m_start});
      if (m_res_vld && !cfg_sync_mode) begin
        if (q_m.size() == 0) chk(1'b0, "R1 unexpected master result", {16'b0, m_res}, 32'b0);
        else begin
          logic [15:0] e;
          e = q_m.pop_front();
          chk(m_res == e, "R1 master result", {16'b0, m_res}, {16'b0, e});
        end
      end
      if (s_res_vld && !cfg_sync_mode) begin
        if (q_s.size() == 0) chk(1'b0, "R1 unexpected slave result", {16'b0, s_res}, 32'b0);
        else begin
          logic [15:0] e;
          e = q_s.pop_front();
          chk(s_res == e, "R1 slave result", {16'b0, s_res}, {16'b0, e});
        end
      end
      if (dma_req) begin
        n_req++;
        if (q_p.size() == 0) chk(1'b0, "R9 unexpected dma_req", pack_dat, 32'b0);
        else begin
          logic [31:0] e;
          e = q_p.pop_front();
          chk(pack_dat == e, "R4 packed word", pack_dat, e);
        end
      end
    end
  end

  task automatic push_ind_m(input int len, input logic [79:0] ch);
    for (int i = 0; i <= len; i++) q_m.push_back({4'b0, mval(ch[i*5 +: 5])});
  endtask

  task automatic push_ind_s(input int len, input logic [79:0] ch);
    for (int i = 0; i <= len; i++) q_s.push_back({4'b0, sval(ch[i*5 +: 5])});
  endtask

  task automatic push_pack(input int len, input logic [79:0] cm, input logic [79:0] cs);
    for (int i = 0; i <= len; i++)
      q_p.push_back({4'b0, sval(cs[i*5 +: 5]), 4'b0, mval(cm[i*5 +: 5])});
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk); trig_src[idx] = 1'b1;
    repeat (3) @(negedge clk);
    trig_src[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_slv();
    @(negedge clk); slv_trig = 1'b1;
    repeat (3) @(negedge clk);
    slv_trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_counts();
    n_mstart = 0; n_sstart = 0; n_irq_m = 0; n_irq_s = 0; n_req = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerrors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [79:0] cm, cs;
    cm = mk_chans(1);
    cs = mk_chans(2);
    rst_n = 1'b0;
    cfg_sync_mode = 1'b0; cfg_dma_en = 1'b0; cfg_ie_m = 1'b1; cfg_ie_s = 1'b1;
    cfg_trig_sel = 3'd5; cfg_len_m = 4'd2; cfg_len_s = 4'd1;
    cfg_chans_m = cm; cfg_chans_s = cs;
    trig_src = '0; slv_trig = 1'b0; m_done = 1'b0; s_done = 1'b0;
    m_data = '0; s_data = '0; dma_ack = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(m_start == 1'b0 && s_start == 1'b0, "R8 reset starts", {30'b0, m_start, s_start}, 32'b0);
    chk(dma_req == 1'b0 && pack_dat == 32'b0, "R9 reset dma", pack_dat, 32'b0);
    chk(cfg_err == 1'b0, "R7 reset cfg_err", {31'b0, cfg_err}, 32'b0);
    chk(overrun == 1'b0, "R11 reset overrun", {31'b0, overrun}, 32'b0);

    // independent mode, busy re-trigger ignored
    dly_m = 6; dly_s = 4;
    clr_counts();
    push_ind_m(2, cm);
    push_ind_s(1, cs);
    fork pulse_src(5); pulse_slv(); join
    repeat (4) @(negedge clk);
    pulse_src(5);
    repeat (80) @(negedge clk);
    chk(q_m.size() == 0, "R1 master queue drained", q_m.size(), 0);
    chk(q_s.size() == 0, "R1 slave queue drained", q_s.size(), 0);
    chk(n_mstart == 3, "R8/R10 master start count", n_mstart, 3);
    chk(n_sstart == 2, "R1/R10 slave start count", n_sstart, 2);
    chk(n_irq_m == 1 && n_irq_s == 1, "R5 irq both", {n_irq_m[15:0], n_irq_s[15:0]}, 32'h0001_0001);

    // synchronous mode
    cfg_sync_mode = 1'b1; cfg_trig_sel = 3'd2; cfg_dma_en = 1'b1;
    cfg_len_m = 4'd3; cfg_len_s = 4'd0;
    dly_m = 2; dly_s = 7;
    clr_counts();
    pulse_src(4);
    repeat (10) @(negedge clk);
    chk(n_mstart == 0, "R2 unselected source ignored", n_mstart, 0);
    push_pack(3, cm, cs);
    pulse_src(2);
    fork pulse_slv(); pulse_src(2); join
    repeat (100) @(negedge clk);
    chk(q_p.size() == 0, "R4 packed queue drained", q_p.size(), 0);
    chk(n_mstart == 4 && n_sstart == 4, "R2/R10 sync starts", {n_mstart[15:0], n_sstart[15:0]}, 32'h0004_0004);
    chk(n_req == 4, "R9 one request per word", n_req, 4);
    chk(n_irq_m == 1 && n_irq_s == 1, "R5 sync irq", {n_irq_m[15:0], n_irq_s[15:0]}, 32'h0001_0001);
    chk(overrun == 1'b0, "R11 no overrun with ack", {31'b0, overrun}, 32'b0);

    // slave trigger while idle in sync mode
    clr_counts();
    pulse_slv();
    repeat (20) @(negedge clk);
    chk(n_sstart == 0 && n_mstart == 0, "R3 slave trigger ignored", n_sstart, 0);

    // dma disabled
    cfg_dma_en = 1'b0;
    pulse_src(2);
    repeat (20) @(negedge clk);
    chk(n_mstart == 0, "R6 no start without dma", n_mstart, 0);

    // channel clash
    cfg_dma_en = 1'b1; cfg_len_m = 4'd2;
    cfg_chans_s = cs;
    cfg_chans_s[2*5 +: 5] = cm[2*5 +: 5];
    pulse_src(2);
    repeat (20) @(negedge clk);
    chk(cfg_err == 1'b1, "R7 clash flagged", {31'b0, cfg_err}, 32'd1);
    chk(n_mstart == 0 && n_sstart == 0, "R7 clash no start", n_mstart, 0);
    cfg_chans_s = cs;
    cfg_chans_s[5*5 +: 5] = cm[5*5 +: 5];
    push_pack(2, cm, cfg_chans_s);
    pulse_src(2);
    repeat (80) @(negedge clk);
    chk(cfg_err == 1'b0, "R7 clash beyond length ignored", {31'b0, cfg_err}, 32'b0);
    chk(n_mstart == 3, "R7/R10 run after clear", n_mstart, 3);
    chk(q_p.size() == 0, "R7 packed words", q_p.size(), 0);
    cfg_chans_s = cs;

    // overrun
    auto_ack = 1'b0; cfg_len_m = 4'd1;
    push_pack(1, cm, cs);
    pulse_src(2);
    repeat (60) @(negedge clk);
    chk(overrun == 1'b1, "R11 overrun set", {31'b0, overrun}, 32'd1);
    repeat (10) @(negedge clk);
    chk(overrun == 1'b1, "R11 overrun sticky", {31'b0, overrun}, 32'd1);

    // full length, master irq disabled
    auto_ack = 1'b1; cfg_ie_m = 1'b0; cfg_len_m = 4'd15;
    dly_m = 4; dly_s = 3;
    clr_counts();
    push_pack(15, cm, cs);
    pulse_src(2);
    repeat (250) @(negedge clk);
    chk(n_mstart == 16 && n_sstart == 16, "R10 sixteen slots", {n_mstart[15:0], n_sstart[15:0]}, 32'h0010_0010);
    chk(n_irq_m == 0, "R5 irq disabled", n_irq_m, 0);
    chk(n_irq_s == 1, "R5 irq enabled", n_irq_s, 1);
    chk(q_p.size() == 0, "R4 long sequence words", q_p.size(), 0);

    // independent single-slot sequence
    cfg_sync_mode = 1'b0; cfg_len_m = 4'd0; cfg_ie_m = 1'b1;
    clr_counts();
    push_ind_m(0, cm);
    pulse_src(2);
    repeat (30) @(negedge clk);
    chk(n_mstart == 1 && n_sstart == 0, "R10/R1 single slot", {n_mstart[15:0], n_sstart[15:0]}, 32'h0001_0000);
    chk(q_m.size() == 0, "R1 single result", q_m.size(), 0);
    chk(n_irq_m == 1, "R5 single slot irq", n_irq_m, 1);

    finish_run();
  end
endmodule